// File: doc/BRIEF.md
# Management Interface Command Engine

This block is a management-interface master for Ethernet PHYs, run through one 32-bit command/status register. Software writes a single word that holds the operation, the PHY and register addresses, the write data and a start flag. The engine then sends a complete Clause 22 MDIO frame on MDC and MDIO. When the frame ends, the start flag clears. For a read, the 16-bit value returned by the PHY is placed in the low half of the same register.

The register layout is fixed as follows. Bits 15:0 hold the data. Bits 20:16 hold the register address and bits 25:21 the PHY address. Bit 26 requests a write, bit 27 requests a read, and bit 29 is the start/busy flag. Software launches a transaction by writing the word with bit 29 set. It then polls bit 29 until the bit reads 0, and for a read it takes the result from bits 15:0. MDC runs at the system clock divided by the parameter `MDC_DIV`. The default of 40 gives 2.5 MHz from a 100 MHz clock.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the register reads 0, MDC is low and MDIO is not driven (`mdioOe` = 0).
- R2: A register write with bit 29 set, made while idle, starts a transaction on the next clock. Bit 29 then reads 1 for exactly 64 x `MDC_DIV` cycles and then reads 0 by itself.
- R3: A frame is 64 MDC cycles, sent MSB first: 32 ones, start bits 01, opcode (10 read, 01 write), PHY address from bits 25:21, register address from bits 20:16, two turnaround bits, then 16 data bits.
- R4: In a write frame the master drives all 64 bits. The turnaround is 10 and the data bits are command bits 15:0. After completion the register reads back the command word with bit 29 cleared.
- R5: In a read frame the master releases MDIO for the last 18 bits (turnaround and data). It samples MDIO on each rising MDC edge of the 16 data bits, MSB first. When busy clears, the value is in bits 15:0, and bits 31:30 and 28:16 keep their written values.
- R6: MDC has a period of `MDC_DIV` clocks. It is low in the first half of each bit and high in the second half, and it stays low while idle.
- R7: A register write arriving while busy has no effect. This includes a write in the very clock in which the transaction completes.
- R8: A register write with bit 29 clear, made while idle, only stores the word. No frame is started.
- R9: When bit 27 is set the operation is a read, whatever bit 26 holds. When bit 27 is clear the operation is a write, even if bit 26 is also clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Word written to the command register |
| rdData | output | 32 | Command/status register readback, busy in bit 29 |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable (0 = released) |
| mdioIn | input | 1 | MDIO value seen on the pin |

## Verification
Two things can land in the same clock: the end of a frame, which clears busy and for a read loads the result, and a software write to the register. The bench provokes this by writing a stray word on every clock for as long as busy reads 1, so one of those writes falls exactly on the completion edge. The register must then hold the completed result and not the stray word. The first write after busy reads 0 must be accepted.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

  // Frame geometry
  localparam int FRAME_BITS = 64;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = 46;   // first turnaround bit index
  localparam int DATA_FIRST = 48;   // first data bit index
  localparam int PRE_BITS   = 32;

  // Command word field positions
  localparam int F_DATA_LSB = 0;
  localparam int F_REG_LSB  = 16;
  localparam int F_PHY_LSB  = 21;
  localparam int F_WR_BIT   = 26;
  localparam int F_RD_BIT   = 27;
  localparam int F_GO_BIT   = 29;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // accept command and build frame
    logic shift;   // advance to the next frame bit (falling MDC)
    logic sample;  // capture mdioIn (rising MDC)
    logic done;    // last bit finished
    logic drive;   // master owns MDIO
  } mdio_stb_t;

  typedef enum logic {ST_IDLE, ST_RUN} mdio_state_t;

endpackage

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int MDC_DIV = 40
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      wrStart,
  input  logic      wrRead,
  output mdio_stb_t stb,
  output logic      busy,
  output logic      mdc
);

  localparam int HALF  = MDC_DIV / 2;
  localparam int DIV_W = $clog2(MDC_DIV);

  mdio_state_t       state;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              rdOp;
  logic              periodEnd;
  logic              lastBit;

  assign busy      = (state == ST_RUN);
  assign periodEnd = busy && (divCnt == DIV_W'(MDC_DIV - 1));
  assign lastBit   = (bitCnt == BIT_W'(FRAME_BITS - 1));

  always_comb begin
    stb.load   = wrEn && !busy && wrStart;
    stb.shift  = periodEnd && !lastBit;
    stb.done   = periodEnd && lastBit;
    stb.sample = busy && rdOp && (bitCnt >= BIT_W'(DATA_FIRST)) &&
                 (divCnt == DIV_W'(HALF - 1));
    stb.drive  = busy && !(rdOp && (bitCnt >= BIT_W'(TA_FIRST)));
  end

  assign mdc = busy && (divCnt >= DIV_W'(HALF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
      rdOp   <= 1'b0;
    end else if (stb.load) begin
      state  <= ST_RUN;
      divCnt <= '0;
      bitCnt <= '0;
      rdOp   <= wrRead;
    end else if (busy) begin
      if (periodEnd) begin
        divCnt <= '0;
        if (lastBit) state <= ST_IDLE;
        else         bitCnt <= bitCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // R2: once launched, busy holds until the completion strobe
  a_r2_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    busy && !stb.done |=> busy);

  // R2: an accepted start makes busy visible on the next clock
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> busy);

  // R2: completion clears busy
  a_r2_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> !busy);

  // R6: each new bit begins with MDC low
  a_r6_low_after_shift: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |=> !mdc);

endmodule

// File: rtl/mdio_cmd_dpath.sv
module mdio_cmd_dpath
  import mdio_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  mdio_stb_t   stb,
  input  logic        busy,
  input  logic        mdioIn,
  output logic [31:0] rdData,
  output logic        mdioOut,
  output logic        mdioOe
);

  logic [31:0]           cmdReg;
  logic [FRAME_BITS-1:0] frameSr;
  logic [15:0]           rdSr;
  logic [FRAME_BITS-1:0] frameWord;
  logic                  isRd;

  assign isRd = wrData[F_RD_BIT];

  always_comb begin
    frameWord = {{PRE_BITS{1'b1}}, 2'b01,
                 isRd ? 2'b10 : 2'b01,
                 wrData[F_PHY_LSB +: 5],
                 wrData[F_REG_LSB +: 5],
                 isRd ? 2'b11 : 2'b10,
                 isRd ? 16'hFFFF : wrData[F_DATA_LSB +: 16]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      frameSr <= '0;
      rdSr    <= '0;
    end else begin
      if (wrEn && !busy) begin
        cmdReg <= wrData;
        cmdReg[F_GO_BIT] <= 1'b0;
      end
      if (stb.load)       frameSr <= frameWord;
      else if (stb.shift) frameSr <= {frameSr[FRAME_BITS-2:0], 1'b1};
      if (stb.sample)     rdSr <= {rdSr[14:0], mdioIn};
      if (stb.done && cmdReg[F_RD_BIT]) cmdReg[F_DATA_LSB +: 16] <= rdSr;
    end
  end

  assign mdioOut = frameSr[FRAME_BITS-1];
  assign mdioOe  = stb.drive;

  always_comb begin
    rdData = cmdReg;
    rdData[F_GO_BIT] = busy;
  end

  // R7: writes during a transaction leave the upper fields untouched
  a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && busy |=> $stable(cmdReg[31:16]));

  // R5: the master has released MDIO whenever it samples
  a_r5_released_on_sample: assert property (@(posedge clk) disable iff (!rstN)
    stb.sample |-> !mdioOe);

  // R3: a frame opens with a driven preamble one
  a_r3_preamble_first: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> mdioOut && mdioOe);

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_cmd_pkg::*;
#(
  parameter int MDC_DIV = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  mdio_stb_t stb;
  logic      busy;

  mdio_cmd_ctrl #(.MDC_DIV(MDC_DIV)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrStart (wrData[F_GO_BIT]),
    .wrRead  (wrData[F_RD_BIT]),
    .stb     (stb),
    .busy    (busy),
    .mdc     (mdc)
  );

  mdio_cmd_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .stb     (stb),
    .busy    (busy),
    .mdioIn  (mdioIn),
    .rdData  (rdData),
    .mdioOut (mdioOut),
    .mdioOe  (mdioOe)
  );

endmodule

// File: tb/mdio_cmd_engine_tb.sv
module mdio_cmd_engine_tb;

  localparam int DIV  = 40;
  localparam int NVEC = 7;

  // stimulus: command word and PHY response
  localparam logic [31:0] VCMD [NVEC] = '{
    32'h2420_1140,   // write phy1 reg0
    32'h2822_0000,   // read  phy1 reg2
    32'hEBFF_0000,   // read  phy31 reg31, top bits set
    32'h27FF_FFFF,   // write phy31 reg31 all ones
    32'h2400_0000,   // write phy0 reg0 zero
    32'h2CA3_1234,   // both op bits -> read (R9)
    32'h2044_BEEF    // no op bit -> write (R9)
  };
  localparam logic [15:0] VRESP [NVEC] = '{
    16'h0000, 16'h004D, 16'hA5C3, 16'h0000, 16'h0000, 16'h5A5A, 16'h0000
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int nChk = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  mdio_cmd_engine #(.MDC_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // simple PHY responder and frame recorder
  logic [63:0] capFrame = '0;
  logic [63:0] capOe = '0;
  int          edgeCnt = 0;
  int          base = 0;
  int          rel;
  logic [15:0] respVal = '0;

  always @(posedge mdc) begin
    capFrame <= {capFrame[62:0], mdioOut};
    capOe    <= {capOe[62:0], mdioOe};
    edgeCnt  <= edgeCnt + 1;
  end

  always @(negedge mdc) begin
    rel = edgeCnt - base;
    if (rel >= 48 && rel < 64) mdioIn <= respVal[4'(63 - rel)];
    else                       mdioIn <= 1'b1;
  end

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expFrame(input logic [31:0] c);
    logic rd;
    rd = c[27];
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, c[25:21], c[20:16],
            2'b10, c[15:0]};
  endfunction

  function automatic logic [31:0] expFinal(input logic [31:0] c,
                                           input logic [15:0] r);
    return {c[31:30], 1'b0, c[28:16], c[27] ? r : c[15:0]};
  endfunction

  // launch a command and wait for busy to clear; returns busy cycles
  task automatic runTxn(input logic [31:0] cmd, input logic [15:0] resp,
                        output int cycles);
    respVal = resp;
    base    = edgeCnt;
    @(negedge clk);
    wrEn = 1'b1; wrData = cmd;
    @(negedge clk);
    wrEn = 1'b0;
    check("R2 busy set", 64'(rdData[29]), 64'd1);
    cycles = 0;
    while (rdData[29]) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic checkFrame(input string tag, input logic [31:0] cmd);
    if (cmd[27]) begin
      check({tag, " R3 read header"}, 64'(capFrame[63:18]), 64'(expFrame(cmd) >> 18));
      check({tag, " R5 release"}, capOe, {{46{1'b1}}, 18'd0});
    end else begin
      check({tag, " R3/R4 write frame"}, capFrame, expFrame(cmd));
      check({tag, " R4 driven"}, capOe, {64{1'b1}});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reg", 64'(rdData), 64'd0);
    check("R1 mdc", 64'(mdc), 64'd0);
    check("R1 oe", 64'(mdioOe), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // table-driven transactions
    for (int i = 0; i < NVEC; i++) begin
      runTxn(VCMD[i], VRESP[i], cyc);
      check("R2/R6 busy cycles", 64'(cyc), 64'(64 * DIV));
      check("R6 mdc edges", 64'(edgeCnt - base), 64'd64);
      checkFrame("vec", VCMD[i]);
      check(VCMD[i][27] ? "R5/R9 result" : "R4/R9 result",
            64'(rdData), 64'(expFinal(VCMD[i], VRESP[i])));
    end

    // R6: idle MDC low, R8: store-only write
    @(negedge clk);
    wrEn = 1'b1; wrData = 32'h0000_1234;
    @(negedge clk);
    wrEn = 1'b0;
    base = edgeCnt;
    repeat (3 * DIV) @(negedge clk);
    check("R8 stored", 64'(rdData), 64'h0000_1234);
    check("R8 no frame", 64'(edgeCnt - base), 64'd0);
    check("R6 idle low", 64'(mdc), 64'd0);

    // R7: mid-transaction write with start ignored
    respVal = 16'h0000;
    base = edgeCnt;
    @(negedge clk);
    wrEn = 1'b1; wrData = 32'h2420_1140;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (500) @(negedge clk);
    wrEn = 1'b1; wrData = 32'h2BFF_5555;
    @(negedge clk);
    wrEn = 1'b0;
    check("R7 busy kept", 64'(rdData[29]), 64'd1);
    while (rdData[29]) @(negedge clk);
    repeat (3 * DIV) @(negedge clk);
    check("R7 single frame", 64'(edgeCnt - base), 64'd64);
    check("R7 value kept", 64'(rdData), 64'h0420_1140);
    checkFrame("R7", 32'h2420_1140);

    // R7: write landing in the completion clock is dropped
    respVal = 16'hC0DE;
    base = edgeCnt;
    @(negedge clk);
    wrEn = 1'b1; wrData = 32'h2822_0000;
    @(negedge clk);
    while (rdData[29]) begin
      wrEn = 1'b1; wrData = 32'h0000_0BAD;
      @(negedge clk);
    end
    wrEn = 1'b0;
    check("R7 completion-cycle write", 64'(rdData), 64'h0822_C0DE);
    @(negedge clk);
    wrEn = 1'b1; wrData = 32'h0000_0BAD;
    @(negedge clk);
    wrEn = 1'b0;
    check("R8 write after done", 64'(rdData), 64'h0000_0BAD);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule